// File: doc/BRIEF.md
# LED Driver Detection-Mode Controller

This block is the digital controller that switches a constant-current LED sink driver between normal operation and output-fault detection. Two host lines have two roles each. The enable/mode line is active low and turns on the channel drive. The latch/mode line is the second one. The block samples both lines on every rising clock edge and recognises two fixed five-sample patterns. One pattern enters detection mode and the other leaves it. A separate active-low mode pin also forces detection mode for as long as it is held low.

In detection mode the host loads all-ones channel data and holds the enable line low so that every channel is driven. Analog sensing is outside this block. Per-channel open-line and short flags arrive as digital inputs. When the enable line returns high after a long enough drive window, the block captures one fault word and pulses a strobe, so that the word is loaded into the serial shift chain. It also pulls an open-drain style error flag low while the captured word holds any fault.

Top module: `led_det_ctrl`

## Requirements
- R1: While rst_n is low, the outputs are held at det_mode_o=0, capture_o=0, result_o=0 and eflag_n_o=1. Assertion of rst_n is asynchronous. Release is synchronised, so the first rising edge that updates state is the third rising edge after rst_n goes high.
- R2: In normal mode, five consecutive rising-edge samples of {oe_mode_i, le_mode_i} equal to 10, 00, 10, 11, 10 set det_mode_o high just after the fifth of those edges.
- R3: In detection mode, five consecutive samples equal to 10, 00, 10, 10, 10 clear the pattern-entered detection state just after the fifth edge.
- R4: The matcher looks only for the pattern that leads to the other mode. An exit pattern sent in normal mode has no effect, and a second entry pattern sent in detection mode has no effect.
- R5: A sample that does not match the expected step restarts the matcher. If that sample equals the first step (10), it counts as step one. A partial pattern never changes the mode.
- R6: A low sample of dm_n_i makes det_mode_o high after that edge. Once dm_n_i is sampled high again, det_mode_o follows the pattern-entered state alone.
- R7: In detection mode, an edge that samples oe_mode_i high after at least EVAL_CYCLES consecutive low samples raises capture_o for exactly one cycle. It also loads result_o with the channel faults from the last low sample.
- R8: A low window shorter than EVAL_CYCLES samples gives no capture, and result_o keeps its value.
- R9: eflag_n_o is low exactly while result_o has any bit set.
- R10: After any cycle in which det_mode_o is low, result_o is zero. In normal mode a low window on oe_mode_i never produces a capture.
- R11: Bit i of a captured word is open_i[i] OR short_i[i] for channel i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| oe_mode_i | input | 1 | Active-low channel enable; also carries the first pattern bit |
| le_mode_i | input | 1 | Latch line; also carries the second pattern bit |
| dm_n_i | input | 1 | Dedicated mode pin; low forces detection mode |
| open_i | input | NCH | Per-channel open-line flags from the sensing stage |
| short_i | input | NCH | Per-channel short flags from the sensing stage |
| det_mode_o | output | 1 | High while in detection mode |
| capture_o | output | 1 | One-cycle strobe: load result_o into the shift chain |
| result_o | output | NCH | Captured per-channel fault word |
| eflag_n_o | output | 1 | Error flag request, low while a fault is reported |

## Verification
The assertions assume that every input is synchronous to clk and stable around the rising edge. They also assume that the fault inputs describe the channels only while the enable line is low. The stimulus changes every input only on the falling clock edge. Its random fault words are produced inside drive windows, and outside those windows they are left at zero. Random segments mix whole entry and exit patterns, partial and broken patterns, short pulses on the mode pin, and drive windows whose lengths straddle EVAL_CYCLES. This keeps the bench within the single-clock, edge-sampled input behaviour that the properties rely on.

// File: rtl/led_det_pkg.sv
package led_det_pkg;

  // Number of samples in a mode-change pattern.
  localparam int unsigned PAT_LEN = 5;
  localparam int unsigned STEP_W  = $clog2(PAT_LEN);

  // One control sample: {enable/mode line, latch/mode line}.
  typedef logic [1:0] ctl_smp_t;

  typedef logic [STEP_W-1:0] pat_step_t;

  // The expected sample at a given step. The two patterns differ only at step 3.
  function automatic ctl_smp_t pattern_at(input logic exit_sel, input pat_step_t idx);
    ctl_smp_t s;
    case (idx)
      pat_step_t'(0): s = 2'b10;
      pat_step_t'(1): s = 2'b00;
      pat_step_t'(2): s = 2'b10;
      pat_step_t'(3): s = exit_sel ? 2'b10 : 2'b11;
      default:        s = 2'b10;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/led_det_rst_sync.sv
module led_det_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic core_rst_n
);

  logic stage1_q;
  logic stage2_q;

  // R1: asserted at once, released on the second edge after rst_n rises
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign core_rst_n = stage2_q;

endmodule

// File: rtl/led_det_seq_match.sv
module led_det_seq_match
  import led_det_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     exit_sel,
  input  ctl_smp_t smp,
  output logic     hit
);

  localparam pat_step_t LAST_STEP = pat_step_t'(PAT_LEN - 1);

  pat_step_t step_q;
  pat_step_t step_d;
  ctl_smp_t  exp_now;
  logic      is_match;
  logic      is_first;
  logic      at_last;

  // R4: exit_sel picks the only pattern that is looked for
  // R5: on a mismatch, restart; a sample equal to step 0 counts as step 1
  always_comb begin
    exp_now  = pattern_at(exit_sel, step_q);
    is_match = (smp == exp_now);
    is_first = (smp == pattern_at(exit_sel, pat_step_t'(0)));
    at_last  = (step_q == LAST_STEP);
    hit      = is_match && at_last;
    if (is_match) begin
      step_d = at_last ? pat_step_t'(0) : step_q + pat_step_t'(1);
    end else begin
      step_d = is_first ? pat_step_t'(1) : pat_step_t'(0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= pat_step_t'(0);
    end else begin
      step_q <= step_d;
    end
  end

endmodule

// File: rtl/led_det_fault_merge.sv
module led_det_fault_merge #(
  parameter int unsigned NCH = 24
) (
  input  logic [NCH-1:0] open_i,
  input  logic [NCH-1:0] short_i,
  output logic [NCH-1:0] fault_o
);

  // R11: one fault bit per channel, either kind
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    assign fault_o[ch] = open_i[ch] | short_i[ch];
  end

endmodule

// File: rtl/led_det_eval_capture.sv
module led_det_eval_capture #(
  parameter int unsigned NCH         = 24,
  parameter int unsigned EVAL_CYCLES = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           det,
  input  logic           oe_n,
  input  logic [NCH-1:0] fault,
  output logic           capture,
  output logic [NCH-1:0] result
);

  localparam int unsigned CW = $clog2(EVAL_CYCLES + 1);
  localparam logic [CW-1:0] EVAL_TGT = CW'(EVAL_CYCLES);

  logic [CW-1:0]  cnt_q,  cnt_d;
  logic [NCH-1:0] hold_q, hold_d;
  logic [NCH-1:0] res_q,  res_d;
  logic           cap_q,  cap_d;
  logic           cnt_en;
  logic           hold_en;

  always_comb begin
    // Saturating count of consecutive low samples of the enable line
    cnt_en = det && !oe_n && (cnt_q != EVAL_TGT);
    if (!det || oe_n) begin
      cnt_d = '0;
    end else if (cnt_en) begin
      cnt_d = cnt_q + CW'(1);
    end else begin
      cnt_d = cnt_q;
    end

    hold_en = det && !oe_n;
    hold_d  = hold_en ? fault : hold_q;

    // R7 / R8: capture only on the rising enable sample after a long enough window
    cap_d = det && oe_n && (cnt_q >= EVAL_TGT);

    // R10: the word is cleared whenever detection mode is off
    if (!det) begin
      res_d = '0;
    end else if (cap_d) begin
      res_d = hold_q;
    end else begin
      res_d = res_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= '0;
      res_q  <= '0;
      cap_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
      res_q  <= res_d;
      cap_q  <= cap_d;
    end
  end

  assign capture = cap_q;
  assign result  = res_q;

endmodule

// File: rtl/led_det_ctrl.sv
module led_det_ctrl
  import led_det_pkg::*;
#(
  parameter int unsigned NCH         = 24,
  parameter int unsigned EVAL_CYCLES = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           oe_mode_i,
  input  logic           le_mode_i,
  input  logic           dm_n_i,
  input  logic [NCH-1:0] open_i,
  input  logic [NCH-1:0] short_i,
  output logic           det_mode_o,
  output logic           capture_o,
  output logic [NCH-1:0] result_o,
  output logic           eflag_n_o
);

  logic           core_rst_n;
  logic           seq_hit;
  logic           seq_det_q, seq_det_d;
  logic           pin_det_q, pin_det_d;
  logic [NCH-1:0] fault_w;
  ctl_smp_t       smp;

  led_det_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_rst_n (core_rst_n)
  );

  assign smp = {oe_mode_i, le_mode_i};

  led_det_seq_match u_match (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .exit_sel (seq_det_q),
    .smp      (smp),
    .hit      (seq_hit)
  );

  // R2 / R3: a complete pattern toggles the pattern-entered state; R6: pin level
  always_comb begin
    seq_det_d = seq_det_q ^ seq_hit;
    pin_det_d = ~dm_n_i;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      seq_det_q <= 1'b0;
      pin_det_q <= 1'b0;
    end else begin
      seq_det_q <= seq_det_d;
      pin_det_q <= pin_det_d;
    end
  end

  assign det_mode_o = seq_det_q | pin_det_q;

  led_det_fault_merge #(.NCH(NCH)) u_merge (
    .open_i  (open_i),
    .short_i (short_i),
    .fault_o (fault_w)
  );

  led_det_eval_capture #(.NCH(NCH), .EVAL_CYCLES(EVAL_CYCLES)) u_eval (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .det     (det_mode_o),
    .oe_n    (oe_mode_i),
    .fault   (fault_w),
    .capture (capture_o),
    .result  (result_o)
  );

  // R9: pull the flag low while the reported word carries any fault
  assign eflag_n_o = ~(|result_o);

endmodule

// File: rtl/led_det_ctrl_chk.sv
module led_det_ctrl_chk #(
  parameter int unsigned NCH = 24
) (
  input logic           clk,
  input logic           core_rst_n,
  input logic           dm_n_i,
  input logic           det_mode_o,
  input logic           capture_o,
  input logic [NCH-1:0] result_o,
  input logic           eflag_n_o
);

  assert_pin_forces_det_R6: assert property (@(posedge clk) disable iff (!core_rst_n)
    !dm_n_i |=> det_mode_o);

  assert_capture_needs_det_R10: assert property (@(posedge clk) disable iff (!core_rst_n)
    !det_mode_o |=> !capture_o);

  assert_capture_one_cycle_R7: assert property (@(posedge clk) disable iff (!core_rst_n)
    capture_o |=> !capture_o);

  assert_capture_after_det_R7: assert property (@(posedge clk) disable iff (!core_rst_n)
    capture_o |-> $past(det_mode_o));

  assert_result_cleared_R10: assert property (@(posedge clk) disable iff (!core_rst_n)
    !det_mode_o |=> (result_o == '0));

  assert_result_holds_R8: assert property (@(posedge clk) disable iff (!core_rst_n)
    det_mode_o |=> (capture_o || $stable(result_o)));

  assert_flag_on_capture_R9: assert property (@(posedge clk) disable iff (!core_rst_n)
    (capture_o && (result_o != '0)) |-> !eflag_n_o);

endmodule

bind led_det_ctrl led_det_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .core_rst_n (core_rst_n),
  .dm_n_i     (dm_n_i),
  .det_mode_o (det_mode_o),
  .capture_o  (capture_o),
  .result_o   (result_o),
  .eflag_n_o  (eflag_n_o)
);

// File: tb/led_det_ctrl_bench.sv
`timescale 1ns/100ps
module led_det_ctrl_bench;

  localparam int NCH  = 24;
  localparam int EVAL = 6;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           oe, le, dm_n;
  logic [NCH-1:0] opn, sht;
  logic           det_mode_o, capture_o, eflag_n_o;
  logic [NCH-1:0] result_o;

  int    n_chk  = 0;
  int    n_fail = 0;
  string ph     = "R1";

  always #2.5 clk = ~clk;

  led_det_ctrl #(.NCH(NCH), .EVAL_CYCLES(EVAL)) u_led_det_ctrl (
    .clk(clk), .rst_n(rst_n), .oe_mode_i(oe), .le_mode_i(le), .dm_n_i(dm_n),
    .open_i(opn), .short_i(sht), .det_mode_o(det_mode_o), .capture_o(capture_o),
    .result_o(result_o), .eflag_n_o(eflag_n_o)
  );

  // Reference model built from the requirements
  int             m_rs;
  int             m_step;
  logic           m_seq, m_pin, m_cap;
  int             m_cnt;
  logic [NCH-1:0] m_hold, m_res;

  function automatic logic [1:0] pat(input logic ex, input int i);
    logic [1:0] e [5] = '{2'b10, 2'b00, 2'b10, 2'b11, 2'b10};
    logic [1:0] x [5] = '{2'b10, 2'b00, 2'b10, 2'b10, 2'b10};
    return ex ? x[i] : e[i];
  endfunction

  function automatic logic exp_det();
    return m_seq | m_pin;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs = 0; m_step = 0; m_seq = 0; m_pin = 0; m_cap = 0;
      m_cnt = 0; m_hold = '0; m_res = '0;
    end else if (m_rs < 2) begin
      m_rs++;
    end else begin
      logic det, hit, cap;
      int   nstep, ncnt;
      logic [1:0] s;
      det = exp_det();
      s   = {oe, le};
      hit = 0;
      if (s == pat(m_seq, m_step)) begin
        hit   = (m_step == 4);
        nstep = hit ? 0 : m_step + 1;
      end else begin
        nstep = (s == 2'b10) ? 1 : 0;
      end
      cap  = det && oe && (m_cnt >= EVAL);
      ncnt = (!det || oe) ? 0 : ((m_cnt < EVAL) ? m_cnt + 1 : m_cnt);
      if (!det) m_res = '0;
      else if (cap) m_res = m_hold;
      if (det && !oe) m_hold = opn | sht;
      m_cap  = cap;
      m_cnt  = ncnt;
      m_step = nstep;
      m_seq  = m_seq ^ hit;
      m_pin  = !dm_n;
    end
  end

  task automatic check(input string tag, input string what, input logic [NCH-1:0] act,
                       input logic [NCH-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Every cycle: compare all outputs with the model, away from the active edge
  always @(negedge clk) begin
    check(ph, "det_mode_o", NCH'(det_mode_o), NCH'(exp_det()));
    check(ph, "capture_o",  NCH'(capture_o),  NCH'(m_cap));
    check(ph, "result_o",   result_o,         m_res);
    check(ph, "eflag_n_o",  NCH'(eflag_n_o),  NCH'(m_res == '0));
  end

  task automatic put(input logic o, input logic l);
    oe = o; le = l;
    @(negedge clk);
  endtask

  task automatic send(input logic ex);
    for (int i = 0; i < 5; i++) begin
      logic [1:0] s;
      s = pat(ex, i);
      put(s[1], s[0]);
    end
  endtask

  task automatic window(input int len, input logic rnd);
    for (int i = 0; i < len; i++) begin
      if (rnd) begin
        opn = NCH'($urandom) & NCH'($urandom);
        sht = NCH'($urandom) & NCH'($urandom) & NCH'($urandom);
      end
      put(1'b0, 1'b0);
    end
    opn = '0; sht = '0;
    put(1'b1, 1'b0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1ed5_0c0d));
    rst_n = 1'b0; oe = 1'b1; le = 1'b0; dm_n = 1'b1; opn = '0; sht = '0;
    @(negedge clk); @(negedge clk);
    // R1: reset values
    check("R1", "det reset", NCH'(det_mode_o), '0);
    check("R1", "eflag reset", NCH'(eflag_n_o), NCH'(1));
    rst_n = 1'b1;
    repeat (4) put(1'b1, 1'b0);

    ph = "R2"; send(1'b0);
    check("R2", "entry", NCH'(det_mode_o), NCH'(1));
    ph = "R4"; send(1'b0);
    check("R4", "second entry ignored", NCH'(det_mode_o), NCH'(1));

    ph = "R7";
    opn = NCH'(1) << 3; sht = NCH'(1) << 10;
    window(EVAL, 1'b0);
    check("R7", "capture strobe", NCH'(capture_o), NCH'(1));
    check("R11", "merged word", result_o, (NCH'(1) << 3) | (NCH'(1) << 10));
    check("R9", "flag low", NCH'(eflag_n_o), '0);
    put(1'b1, 1'b0);
    check("R7", "strobe one cycle", NCH'(capture_o), '0);

    ph = "R8";
    opn = NCH'(2);
    window(EVAL - 1, 1'b0);
    check("R8", "short window", NCH'(capture_o), '0);
    check("R8", "word kept", result_o, (NCH'(1) << 3) | (NCH'(1) << 10));

    ph = "R3"; send(1'b1);
    check("R3", "exit", NCH'(det_mode_o), '0);
    put(1'b1, 1'b0);
    check("R10", "word cleared", result_o, '0);
    check("R9", "flag high", NCH'(eflag_n_o), NCH'(1));
    ph = "R4"; send(1'b1);
    check("R4", "second exit ignored", NCH'(det_mode_o), '0);

    ph = "R10";
    opn = '1;
    window(EVAL + 2, 1'b0);
    check("R10", "no capture in normal mode", NCH'(capture_o), '0);

    ph = "R5";
    put(1'b1,1'b0); put(1'b0,1'b0); put(1'b1,1'b0); put(1'b0,1'b0);
    put(1'b1,1'b0); put(1'b1,1'b1); put(1'b1,1'b0);
    check("R5", "broken pattern no change", NCH'(det_mode_o), '0);
    put(1'b1,1'b0); send(1'b0);
    check("R5", "restart on first step", NCH'(det_mode_o), NCH'(1));
    send(1'b1);

    ph = "R6";
    dm_n = 1'b0; put(1'b1, 1'b0);
    check("R6", "pin forces det", NCH'(det_mode_o), NCH'(1));
    dm_n = 1'b1; put(1'b1, 1'b0);
    check("R6", "pin release", NCH'(det_mode_o), '0);

    ph = "R7";
    for (int it = 0; it < 400; it++) begin
      int k;
      k = int'($urandom_range(0, 5));
      case (k)
        0: send(1'b0);
        1: send(1'b1);
        2: begin
          int n;
          n = int'($urandom_range(1, 4));
          for (int j = 0; j < n; j++) put(1'($urandom), 1'($urandom));
        end
        3: window(int'($urandom_range(EVAL - 2, EVAL + 3)), 1'b1);
        4: begin
          int n;
          n = int'($urandom_range(1, 3));
          dm_n = 1'b0;
          for (int j = 0; j < n; j++) put(1'b1, 1'b0);
          dm_n = 1'b1;
          put(1'b1, 1'b0);
        end
        default: begin
          put(1'b1,1'b0); put(1'b0,1'b0); put(1'b1,1'b0); put(1'b0,1'b1);
        end
      endcase
    end
    put(1'b1, 1'b0);
    finish_run();
  end

endmodule